// File: doc/BRIEF.md
# DMA Pointer Loader and Byte-to-Word Packer

This block sits between a SCSI protocol core and a 16-bit big-endian host memory bus on a controller card. Software writes a 32-bit DMA pointer into a small register window one byte at a time. Bit 31 of the pointer gives the direction, and bits 30:0 hold a word address. When the last byte of the pointer arrives, the block raises `dma_en` towards the core. It then moves data between the core's byte streams and the memory bus, one 16-bit word per bus request. After every word the pointer steps by one.

The parameter `LANE_MODE` chooses between two ways of loading the pointer:

- **Shift mode** (`LANE_MODE=0`). A write to the reset key clears the pointer and arms a four-byte count. Each later byte shifts into the pointer from the bottom.
- **Lane mode** (`LANE_MODE=1`). Each of the four byte lanes has its own window offset. A write to the most significant lane completes the load.

The transfer controller has seven states:

- `ST_IDLE`: no valid pointer.
- `ST_GET_HI` and `ST_GET_LO`: collect a byte pair from the core.
- `ST_WR_MEM`: issue a memory write.
- `ST_RD_MEM`: issue a memory read.
- `ST_PUT_HI` and `ST_PUT_LO`: hand the fetched bytes to the core.

Transitions:

- From any state, a completing load goes to `ST_GET_HI` when bit 31 is 0, or to `ST_RD_MEM` when bit 31 is 1.
- From any state, a window write that does not complete a load goes to `ST_IDLE`.
- In the write direction:
  - `ST_GET_HI` goes to `ST_GET_LO` on a byte without last, or to `ST_WR_MEM` on a byte with last.
  - `ST_GET_LO` goes to `ST_WR_MEM` on a byte.
  - `ST_WR_MEM` goes to `ST_GET_HI` on acknowledge, or to `ST_IDLE` on acknowledge when the last byte was included.
- In the read direction:
  - `ST_RD_MEM` goes to `ST_PUT_HI` on acknowledge.
  - `ST_PUT_HI` goes to `ST_PUT_LO` when the byte is taken, or to `ST_IDLE` when it is taken with `m_last`.
  - `ST_PUT_LO` goes to `ST_RD_MEM` when the byte is taken, or to `ST_IDLE` when it is taken with `m_last`.

Top module: `dma_ptr_packer`

## Requirements
- R1: After reset, `dma_en`, `mem_req`, `s_ready` and `m_valid` are low, and in shift mode the pending byte count is zero.
- R2: In shift mode:
  - A window write whose two top offset bits are both 1 (offset 0x18000 with the default 17-bit window) clears the pointer and sets the pending count to 4.
  - Any other window write shifts the pointer left by 8 and puts the byte in bits 7:0. If the count is nonzero it is decremented, and the load completes when it reaches 0.
  - With the count at 0, writes never complete a load.
- R3: In lane mode, a window write replaces pointer byte lane `3 - offset[3:2]` (lane n covers bits 8n+7..8n). Offset bits other than 3:2 are ignored. Only a write to lane 3 (offset[3:2] = 0) completes the load.
- R4: Any window write that does not complete a load makes `dma_en` low in the following cycle. It also abandons the transfer in progress, including a partly gathered byte pair. A completing write raises `dma_en` in the following cycle.
- R5: Each word's bus address is pointer bits 30:0 shifted left by one. When pointer bit 31 is 0, bytes flow from the core into memory writes (`mem_we`=1). When it is 1, memory reads feed the core.
- R6: Write packing is big-endian: the first byte goes in bits 15:8 and the second in bits 7:0. A final odd byte gives a word with bits 7:0 zero. A write request is raised only once a pair is held or the last byte has arrived.
- R7: In the read direction, each fetched word is offered as bits 15:8 and then bits 7:0. If the core takes the high byte with `m_last` set, the low byte is not offered.
- R8: The pointer increases by one for each acknowledged word. The transfer ends and `dma_en` falls after the word holding the last byte completes.
- R9: Once raised, `mem_req` stays high until `mem_ack`, with address, direction and write data unchanged, unless a window write intervenes.
- R10: When a window write and `mem_ack` fall in the same cycle, the write's effect on the pointer is kept and that word's increment is dropped.
- R11: Reads of the window (`cfg_rdata`) always return 0.
- R12: `s_ready` and `m_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Byte write strobe into the DMA window |
| cfg_addr | input | WIN_AW | Offset within the DMA window |
| cfg_wdata | input | 8 | Written byte |
| cfg_rdata | output | 8 | Window read data, always zero |
| dma_en | output | 1 | High while a loaded pointer is active |
| s_valid | input | 1 | Core byte valid (memory write direction) |
| s_data | input | 8 | Core byte |
| s_last | input | 1 | Marks the final byte of the transfer |
| s_ready | output | 1 | Block accepts the core byte |
| m_valid | output | 1 | Byte for the core is valid (memory read direction) |
| m_data | output | 8 | Byte for the core |
| m_ready | input | 1 | Core takes the byte |
| m_last | input | 1 | Core marks the taken byte as final |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 16 | Word to write |
| mem_rdata | input | 16 | Word read, valid with `mem_ack` |
| mem_ack | input | 1 | Request completes this cycle |

## Verification
A pointer window write and a memory acknowledge can land on the same clock edge, so the pointer update from software competes with the hardware step. The bench provokes this in lane mode. It waits for the memory model's acknowledge and drives a lane write in that very cycle. It then completes the load and checks the address of the next word: an applied lane byte with no increment is correct. A second overlap, a reset-key write during a half-gathered pair, is judged by `dma_en` dropping and by the next logged word holding only freshly sent bytes.

// File: rtl/dma_pk_pkg.sv
`timescale 1ns/1ps
package dma_pk_pkg;
    localparam int PTR_W   = 32;
    localparam int LANES   = PTR_W / 8;
    localparam int WORD_W  = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GET_HI,
        ST_GET_LO,
        ST_WR_MEM,
        ST_RD_MEM,
        ST_PUT_HI,
        ST_PUT_LO
    } xfer_state_e;
endpackage

// File: rtl/dma_ptr_loader.sv
`timescale 1ns/1ps
module dma_ptr_loader
    import dma_pk_pkg::*;
#(
    parameter int WIN_AW    = 17,
    parameter int LANE_MODE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [WIN_AW-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              inc,
    output logic [PTR_W-1:0]  ptr,
    output logic              load_done,
    output logic              load_abort,
    output logic              load_dir
);
    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] ptr_wr;

    generate
        if (LANE_MODE != 0) begin : g_lane
            logic [1:0] sel;
            assign sel = 2'(LANES - 1) - addr[3:2];
            always_comb begin
                ptr_wr = ptr_q;
                for (int l = 0; l < LANES; l++) begin
                    if (sel == 2'(l)) ptr_wr[l*8 +: 8] = wdata;
                end
            end
            assign load_done = wr && (sel == 2'(LANES - 1));
        end else begin : g_shift
            logic [2:0] pend_q;
            logic       key;
            assign key = &addr[WIN_AW-1:WIN_AW-2];
            always_ff @(posedge clk) begin
                if (!rst_n)
                    pend_q <= '0;
                else if (wr)
                    pend_q <= key ? 3'(LANES) : ((pend_q != 3'd0) ? pend_q - 3'd1 : 3'd0);
            end
            assign ptr_wr    = key ? '0 : {ptr_q[PTR_W-9:0], wdata};
            assign load_done = wr && !key && (pend_q == 3'd1);
        end
    endgenerate

    // A window write always wins over the per-word step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (wr)
            ptr_q <= ptr_wr;
        else if (inc)
            ptr_q <= ptr_q + 1'b1;
    end

    assign ptr        = ptr_q;
    assign load_abort = wr && !load_done;
    assign load_dir   = ptr_wr[PTR_W-1];
endmodule

// File: rtl/dma_word_fsm.sv
`timescale 1ns/1ps
module dma_word_fsm
    import dma_pk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_done,
    input  logic              load_abort,
    input  logic              load_dir,
    input  logic              s_valid,
    input  logic [7:0]        s_data,
    input  logic              s_last,
    output logic              s_ready,
    output logic              m_valid,
    output logic [7:0]        m_data,
    input  logic              m_ready,
    input  logic              m_last,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              ptr_inc,
    output logic              dma_en
);
    xfer_state_e      state_q, state_d;
    logic [WORD_W-1:0] word_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (load_done) begin
            state_d = load_dir ? ST_RD_MEM : ST_GET_HI;
        end else if (load_abort) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_IDLE;
                ST_GET_HI: if (s_valid) state_d = s_last ? ST_WR_MEM : ST_GET_LO;
                ST_GET_LO: if (s_valid) state_d = ST_WR_MEM;
                ST_WR_MEM: if (mem_ack) state_d = last_q ? ST_IDLE : ST_GET_HI;
                ST_RD_MEM: if (mem_ack) state_d = ST_PUT_HI;
                ST_PUT_HI: if (m_ready) state_d = m_last ? ST_IDLE : ST_PUT_LO;
                ST_PUT_LO: if (m_ready) state_d = m_last ? ST_IDLE : ST_RD_MEM;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            last_q <= 1'b0;
        end else begin
            if (state_q == ST_GET_HI && s_valid) begin
                word_q <= {s_data, 8'h00};
                last_q <= s_last;
            end
            if (state_q == ST_GET_LO && s_valid) begin
                word_q[7:0] <= s_data;
                last_q      <= s_last;
            end
            if (state_q == ST_RD_MEM && mem_ack)
                word_q <= mem_rdata;
        end
    end

    always_comb begin
        s_ready   = (state_q == ST_GET_HI) || (state_q == ST_GET_LO);
        m_valid   = (state_q == ST_PUT_HI) || (state_q == ST_PUT_LO);
        m_data    = (state_q == ST_PUT_HI) ? word_q[15:8] : word_q[7:0];
        mem_req   = (state_q == ST_WR_MEM) || (state_q == ST_RD_MEM);
        mem_we    = (state_q == ST_WR_MEM);
        mem_wdata = word_q;
        ptr_inc   = mem_req && mem_ack;
        dma_en    = (state_q != ST_IDLE);
    end
endmodule

// File: rtl/dma_ptr_packer.sv
`timescale 1ns/1ps
module dma_ptr_packer
    import dma_pk_pkg::*;
#(
    parameter int WIN_AW    = 17,
    parameter int LANE_MODE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [WIN_AW-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    output logic              dma_en,
    input  logic              s_valid,
    input  logic [7:0]        s_data,
    input  logic              s_last,
    output logic              s_ready,
    output logic              m_valid,
    output logic [7:0]        m_data,
    input  logic              m_ready,
    input  logic              m_last,
    output logic              mem_req,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [15:0]       mem_wdata,
    input  logic [15:0]       mem_rdata,
    input  logic              mem_ack
);
    logic [PTR_W-1:0] ptr;
    logic             load_done, load_abort, load_dir, ptr_inc;

    dma_ptr_loader #(.WIN_AW(WIN_AW), .LANE_MODE(LANE_MODE)) u_loader (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .addr(cfg_addr), .wdata(cfg_wdata),
        .inc(ptr_inc), .ptr(ptr), .load_done(load_done), .load_abort(load_abort),
        .load_dir(load_dir)
    );

    dma_word_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .load_done(load_done), .load_abort(load_abort),
        .load_dir(load_dir), .s_valid(s_valid), .s_data(s_data), .s_last(s_last),
        .s_ready(s_ready), .m_valid(m_valid), .m_data(m_data), .m_ready(m_ready),
        .m_last(m_last), .mem_req(mem_req), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .ptr_inc(ptr_inc), .dma_en(dma_en)
    );

    assign mem_addr  = {ptr[PTR_W-2:0], 1'b0};
    assign cfg_rdata = '0;
endmodule

// File: rtl/dma_ptr_packer_chk.sv
`timescale 1ns/1ps
module dma_ptr_packer_chk #(
    parameter int WIN_AW    = 17,
    parameter int LANE_MODE = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr,
    input logic [WIN_AW-1:0] cfg_addr,
    input logic              dma_en,
    input logic              s_ready,
    input logic              m_valid,
    input logic              m_ready,
    input logic              m_last,
    input logic              mem_req,
    input logic              mem_we,
    input logic [31:0]       mem_addr,
    input logic [15:0]       mem_wdata,
    input logic              mem_ack
);
    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !cfg_wr) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R12
    one_dir_chk: assert property (@(posedge clk) disable iff (!rst_n) !(s_ready && m_valid));

    // R5
    req_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> dma_en);

    // R7
    rd_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_ready && m_last && !cfg_wr) |=> !dma_en);

    generate
        if (LANE_MODE != 0) begin : g_lane
            // R4
            abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_wr && cfg_addr[3:2] != 2'd0) |=> !dma_en);
            // R3
            done_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_wr && cfg_addr[3:2] == 2'd0) |=> dma_en);
        end else begin : g_shift
            // R4
            abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_wr && (&cfg_addr[WIN_AW-1:WIN_AW-2])) |=> !dma_en);
        end
    endgenerate
endmodule

bind dma_ptr_packer dma_ptr_packer_chk #(.WIN_AW(WIN_AW), .LANE_MODE(LANE_MODE)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .dma_en(dma_en),
    .s_ready(s_ready), .m_valid(m_valid), .m_ready(m_ready), .m_last(m_last),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack)
);

// File: tb/dma_ptr_packer_tb.sv
`timescale 1ns/1ps
module dma_ptr_packer_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [16:0] cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        wr_a = 1'b0, wr_b = 1'b0;
    logic        s_valid = 1'b0, s_last = 1'b0, m_ready = 1'b0, m_last = 1'b0;
    logic [7:0]  s_data = '0;
    logic        stall_a = 1'b0;

    logic [7:0]  a_rd, b_rd, a_md, b_md;
    logic        a_en, b_en, a_sr, b_sr, a_mv, b_mv, a_req, b_req, a_we, b_we;
    logic [31:0] a_addr, b_addr;
    logic [15:0] a_wd, b_wd, a_rdata, b_rdata;
    logic        a_ack, b_ack;

    int tests = 0, fails = 0, both_hits = 0;
    bit done = 1'b0;

    function automatic logic [15:0] rdw(input logic [31:0] a);
        return {a[8:1] ^ 8'h3C, a[8:1] + 8'h11};
    endfunction
    assign a_rdata = rdw(a_addr);
    assign b_rdata = rdw(b_addr);

    dma_ptr_packer #(.WIN_AW(17), .LANE_MODE(0)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(wr_a), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(a_rd), .dma_en(a_en), .s_valid(s_valid), .s_data(s_data), .s_last(s_last),
        .s_ready(a_sr), .m_valid(a_mv), .m_data(a_md), .m_ready(m_ready), .m_last(m_last),
        .mem_req(a_req), .mem_we(a_we), .mem_addr(a_addr), .mem_wdata(a_wd),
        .mem_rdata(a_rdata), .mem_ack(a_ack));

    dma_ptr_packer #(.WIN_AW(17), .LANE_MODE(1)) u_dut_lane (
        .clk(clk), .rst_n(rst_n), .cfg_wr(wr_b), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(b_rd), .dma_en(b_en), .s_valid(s_valid), .s_data(s_data), .s_last(s_last),
        .s_ready(b_sr), .m_valid(b_mv), .m_data(b_md), .m_ready(m_ready), .m_last(m_last),
        .mem_req(b_req), .mem_we(b_we), .mem_addr(b_addr), .mem_wdata(b_wd),
        .mem_rdata(b_rdata), .mem_ack(b_ack));

    // memory models with word logs
    logic [31:0] la_addr [64];
    logic [15:0] la_data [64];
    logic [31:0] lb_addr [64];
    logic [15:0] lb_data [64];
    int na = 0, nb = 0, ra = 0, rb = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            a_ack <= 1'b0; b_ack <= 1'b0;
        end else begin
            a_ack <= a_req && !a_ack && !stall_a;
            b_ack <= b_req && !b_ack;
            if (a_req && a_ack) begin
                if (a_we) begin la_addr[na % 64] <= a_addr; la_data[na % 64] <= a_wd; na <= na + 1; end
                else ra <= ra + 1;
            end
            if (b_req && b_ack) begin
                if (b_we) begin lb_addr[nb % 64] <= b_addr; lb_data[nb % 64] <= b_wd; nb <= nb + 1; end
                else rb <= rb + 1;
            end
            if ((a_sr || b_sr) && (a_mv || b_mv) && (a_sr && a_mv || b_sr && b_mv)) both_hits <= both_hits + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic en_of(input bit sel);
        return sel ? b_en : a_en;
    endfunction

    task automatic cfg_write(input bit sel, input logic [16:0] a, input logic [7:0] d);
        cfg_addr = a; cfg_wdata = d;
        if (sel) wr_b = 1'b1; else wr_a = 1'b1;
        @(negedge clk);
        wr_a = 1'b0; wr_b = 1'b0;
    endtask

    task automatic load_shift(input logic [31:0] p);
        cfg_write(0, 17'h18000, 8'h00);
        for (int i = 0; i < 4; i++) cfg_write(0, 17'h00100, p[31-8*i -: 8]);
    endtask

    task automatic load_lane(input logic [31:0] p);
        cfg_write(1, 17'h0000C, p[7:0]);
        cfg_write(1, 17'h00008, p[15:8]);
        cfg_write(1, 17'h00004, p[23:16]);
        cfg_write(1, 17'h00000, p[31:24]);
    endtask

    task automatic push(input logic [7:0] b, input logic last);
        logic r;
        s_valid = 1'b1; s_data = b; s_last = last; r = 1'b0;
        while (!r) begin
            #0.5; r = a_sr | b_sr;
            @(negedge clk);
        end
        s_valid = 1'b0; s_last = 1'b0;
    endtask

    task automatic pull(output logic [7:0] d, input logic last);
        logic v;
        m_ready = 1'b1; m_last = last; v = 1'b0; d = '0;
        while (!v) begin
            #0.5; v = a_mv | b_mv; d = a_mv ? a_md : b_md;
            @(negedge clk);
        end
        m_ready = 1'b0; m_last = 1'b0;
    endtask

    task automatic wait_idle(input bit sel);
        for (int i = 0; i < 50; i++) begin
            if (!en_of(sel)) break;
            @(negedge clk);
        end
    endtask

    function automatic logic [7:0] bval(input logic [7:0] seed, input int i);
        return seed + 8'(7 * i);
    endfunction

    task automatic xfer_wr(input bit sel, input logic [31:0] p, input int n, input logic [7:0] seed);
        int start, words;
        logic [15:0] ew;
        start = sel ? nb : na;
        words = (n + 1) / 2;
        for (int i = 0; i < n; i++) push(bval(seed, i), i == n - 1);
        wait_idle(sel);
        chk("R8 end of write", {31'd0, en_of(sel)}, 32'd0);
        chk("R8 word count", sel ? nb - start : na - start, words);
        for (int w = 0; w < words; w++) begin
            ew[15:8] = bval(seed, 2 * w);
            ew[7:0]  = (2 * w + 1 < n) ? bval(seed, 2 * w + 1) : 8'h00;
            chk("R5 write addr", sel ? lb_addr[(start + w) % 64] : la_addr[(start + w) % 64],
                {31'(p[30:0] + 31'(w)), 1'b0});
            chk("R6 packed word", {16'd0, sel ? lb_data[(start + w) % 64] : la_data[(start + w) % 64]},
                {16'd0, ew});
        end
    endtask

    task automatic xfer_rd(input bit sel, input logic [31:0] p, input int n);
        int start;
        logic [7:0] d;
        logic [15:0] w;
        start = sel ? rb : ra;
        for (int i = 0; i < n; i++) begin
            pull(d, i == n - 1);
            w = rdw({31'(p[30:0] + 31'(i / 2)), 1'b0});
            chk("R7 read byte", {24'd0, d}, {24'd0, (i % 2) ? w[7:0] : w[15:8]});
        end
        wait_idle(sel);
        chk("R8 end of read", {31'd0, en_of(sel)}, 32'd0);
        chk("R7 read count", sel ? rb - start : ra - start, (n + 1) / 2);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog act=timeout exp=finish");
        finish_run();
    end

    initial begin
        logic [31:0] p;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 en", {30'd0, a_en, b_en}, 32'd0);
        chk("R1 req", {30'd0, a_req, b_req}, 32'd0);
        chk("R1 streams", {28'd0, a_sr, b_sr, a_mv, b_mv}, 32'd0);
        chk("R11 rdata", {16'd0, a_rd, b_rd}, 32'd0);

        // R2: count starts at zero, plain writes never complete
        for (int i = 0; i < 4; i++) cfg_write(0, 17'h00100, 8'h11);
        chk("R2 no key no enable", {31'd0, a_en}, 32'd0);

        // R2: key then four bytes
        p = 32'h00001234;
        cfg_write(0, 17'h18000, 8'h00);
        for (int i = 0; i < 3; i++) cfg_write(0, 17'h00100, p[31-8*i -: 8]);
        chk("R2 partial load", {31'd0, a_en}, 32'd0);
        cfg_write(0, 17'h00100, p[7:0]);
        chk("R2 load complete", {31'd0, a_en}, 32'd1);
        chk("R11 rdata active", {24'd0, a_rd}, 32'd0);
        xfer_wr(0, p, 3, 8'h21);

        // sweep write lengths in shift mode
        for (int n = 1; n <= 6; n++) begin
            p = 32'h00001230 + 32'(n * 256);
            load_shift(p);
            xfer_wr(0, p, n, 8'(n * 17));
        end

        // R6: no request with one byte held
        p = 32'h00000500;
        load_shift(p);
        push(8'hC1, 1'b0);
        repeat (3) @(negedge clk);
        chk("R6 no request on half pair", {31'd0, a_req}, 32'd0);
        push(8'hC2, 1'b1);
        wait_idle(0);
        chk("R6 pair word", {16'd0, la_data[(na - 1) % 64]}, 32'h0000C1C2);

        // R9: hold request while memory stalls
        p = 32'h00000600;
        load_shift(p);
        stall_a = 1'b1;
        push(8'hD1, 1'b0);
        push(8'hD2, 1'b1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R9 request held", {31'd0, a_req}, 32'd1);
            chk("R9 address held", a_addr, 32'h00000C00);
        end
        stall_a = 1'b0;
        wait_idle(0);
        chk("R9 word after stall", {16'd0, la_data[(na - 1) % 64]}, 32'h0000D1D2);

        // read sweep in shift mode, bit 31 set
        for (int n = 1; n <= 5; n++) begin
            p = 32'h80000400 + 32'(n * 8);
            load_shift(p);
            xfer_rd(0, p, n);
        end

        // R4: abort mid-pair with the reset key
        load_shift(32'h00000777);
        push(8'hAB, 1'b0);
        cfg_write(0, 17'h18000, 8'h00);
        chk("R4 abort drops enable", {31'd0, a_en}, 32'd0);
        chk("R4 abort stops stream", {31'd0, a_sr}, 32'd0);
        load_shift(32'h00000888);
        xfer_wr(0, 32'h00000888, 2, 8'h40);

        // R4: extra byte after complete load
        load_shift(32'h00000999);
        cfg_write(0, 17'h00100, 8'h55);
        chk("R4 stray write drops enable", {31'd0, a_en}, 32'd0);

        // R3: lane loading with aliased offsets
        cfg_write(1, 17'h0001C, 8'h20);
        cfg_write(1, 17'h00004, 8'h00);
        cfg_write(1, 17'h00008, 8'h10);
        chk("R3 lanes 0..2 no enable", {31'd0, b_en}, 32'd0);
        cfg_write(1, 17'h00010, 8'h80);
        chk("R3 lane 3 enables", {31'd0, b_en}, 32'd1);
        xfer_rd(1, 32'h80001020, 3);

        // lane-mode write sweep
        for (int n = 2; n <= 5; n += 3) begin
            p = 32'h00000A00 + 32'(n);
            load_lane(p);
            xfer_wr(1, p, n, 8'(n * 5));
        end

        // R10: lane write in the acknowledge cycle
        load_lane(32'h00204060);
        push(8'hE1, 1'b0);
        push(8'hE2, 1'b0);
        for (int i = 0; i < 10; i++) begin
            if (b_ack) break;
            @(negedge clk);
        end
        cfg_write(1, 17'h00008, 8'h99);
        chk("R10 write abort", {31'd0, b_en}, 32'd0);
        cfg_write(1, 17'h00000, 8'h00);
        chk("R10 reload enables", {31'd0, b_en}, 32'd1);
        xfer_wr(1, 32'h00209960, 2, 8'h70);

        // R12 monitor
        chk("R12 never both directions", both_hits, 0);
        chk("R11 rdata end", {16'd0, a_rd, b_rd}, 32'd0);
        finish_run();
    end
endmodule